// File: doc/BRIEF.md
# Interleaved Bank Row/Column Strobe Sequencer

This block drives the active-low row strobe (RAS) and column strobe (CAS) lines of a DRAM or video RAM array split into four banks. Each request carries a two-bit bank select, normally wired to the lowest address bits, so that sequential accesses rotate across banks. Every strobe line has its own timing engine with an active timer and a precharge timer. Because of this, a request to a bank that is not recovering can start on the next clock, and only a repeat hit on a recovering bank has to wait.

Two mode inputs shape the traffic. The dual-row mode fires two RAS lines per access, and the pair is chosen by the low select bit alone. The overlap mode lets RAS strobes of different banks be low at the same time. With overlap off, every RAS line must be high for at least one clock between two accesses, so that a CAS can never lead a RAS and be taken as a refresh. A combinational `ready_o` tells the requester whether the request it presents now would be taken at the next edge. The requester holds `req_i` until it sees `ready_o` high.

Top module: `bank_strobe_seq`

## Requirements
- R1: After reset, all RAS and CAS outputs are high and `ready_o` is high for every bank select and mode.
- R2: With the dual-row mode off, a request is accepted at a rising edge where `req_i` and `ready_o` are both high. RAS line number `bank_sel_i` then goes low from that edge for exactly ACC_CYC clocks. No other line changes because of it.
- R3: The CAS line of an accessed line falls RCD_CYC clocks after its RAS falls, and rises on the same edge as its RAS. A CAS line is never low while its RAS line is high.
- R4: After a line's RAS rises, `ready_o` stays low for any request that targets that line for PRE_CYC clocks. With overlap on and repeated requests, that RAS is high for exactly PRE_CYC+1 clocks.
- R5: With overlap on, a request to a line that is neither active nor precharging sees `ready_o` high, whatever the other lines are doing.
- R6: With overlap off, `ready_o` is low while any RAS line is low. Consecutive accesses are therefore separated by at least one clock with all RAS lines high.
- R7: With overlap on, RAS strobes of different lines can be low in the same clock.
- R8: With the dual-row mode on, `bank_sel_i[1]` is ignored. The two lines whose index bit 0 equals `bank_sel_i[0]` (lines 0 and 2, or lines 1 and 3) start together, and `ready_o` needs both of them to be free.
- R9: A request presented while `ready_o` is low changes no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, held until accepted |
| bank_sel_i | input | 2 | Bank select for the request |
| dual_ras_i | input | 1 | 1: two RAS lines per access |
| pipe_en_i | input | 1 | 1: RAS strobes of different banks may overlap |
| ready_o | output | 1 | Request would be accepted at the next edge |
| ras_n_o | output | 4 | Row strobes, active low, one per line |
| cas_n_o | output | 4 | Column strobes, active low, one per line |

## Verification
A line timer stuck in its active state keeps its RAS low. With overlap off, that blocks `ready_o` for every bank within one clock. A precharge count that is off by one moves the first clock at which a repeat request to the same line is granted, and that shows in `ready_o` on the clock where the count ends. A wrong line mask or wrong CAS delay appears on the strobe pins in the first or the RCD_CYC-th clock after acceptance. The bench compares every pin against a clock-by-clock model on every cycle, so each of these faults is caught within a few clocks of the access that exposes it.

// File: rtl/ras_seq_pkg.sv
// Package: shared constants and types for the bank strobe sequencer.
// Assumes four strobe lines addressed by a two-bit select.
package ras_seq_pkg;
    localparam int LINE_CNT = 4;
    localparam int SEL_W    = 2;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_ACT  = 2'd1,
        LN_PRE  = 2'd2
    } line_st_e;
endpackage

// File: rtl/ras_line_timer.sv
// Module: timing engine for one RAS/CAS line pair.
// On start_i (legal only while idle) RAS goes low for ACC_CYC clocks and CAS
// joins RCD_CYC clocks later. Both rise together, and the line then recovers
// for PRE_CYC clocks before it reports idle again.
// Assumes PRE_CYC >= 1, RCD_CYC >= 1, ACC_CYC > RCD_CYC.
module ras_line_timer
    import ras_seq_pkg::*;
#(
    parameter int ACC_CYC = 5,
    parameter int RCD_CYC = 2,
    parameter int PRE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic idle_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    localparam int MAX_CYC = (ACC_CYC > PRE_CYC) ? ACC_CYC : PRE_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] ACC_LD = TW'(ACC_CYC - 1);
    localparam logic [TW-1:0] PRE_LD = TW'(PRE_CYC - 1);
    localparam logic [TW-1:0] CAS_TH = TW'(ACC_CYC - 1 - RCD_CYC);

    line_st_e        st_q;
    logic [TW-1:0]   tmr_q;

    // Phase sequencing: idle -> active -> precharge -> idle, one timer shared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LN_IDLE;
            tmr_q <= '0;
        end else begin
            case (st_q)
                LN_IDLE: begin
                    if (start_i) begin
                        st_q  <= LN_ACT;
                        tmr_q <= ACC_LD;
                    end
                end
                LN_ACT: begin
                    if (tmr_q == '0) begin
                        st_q  <= LN_PRE;
                        tmr_q <= PRE_LD;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                LN_PRE: begin
                    if (tmr_q == '0) begin
                        st_q <= LN_IDLE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                default: st_q <= LN_IDLE;
            endcase
        end
    end

    // Strobe decode from the registered phase and timer.
    always_comb begin
        idle_o  = (st_q == LN_IDLE);
        ras_n_o = (st_q != LN_ACT);
        cas_n_o = !((st_q == LN_ACT) && (tmr_q <= CAS_TH));
    end

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (st_q == LN_IDLE));

    // R3
    cas_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> !$past(ras_n_o));

    // R3
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> $rose(cas_n_o));

    // R4
    precharge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |=> ras_n_o);
endmodule

// File: rtl/ras_grant_logic.sv
// Module: decides which lines a request targets and whether it may start now.
// Single mode targets the line numbered by the select; dual mode targets the
// two lines whose index bit 0 matches select bit 0. Without overlap a request
// waits until every RAS line is high.
module ras_grant_logic
    import ras_seq_pkg::*;
(
    input  logic [SEL_W-1:0]    bank_sel_i,
    input  logic                dual_i,
    input  logic                pipe_i,
    input  logic [LINE_CNT-1:0] idle_i,
    input  logic [LINE_CNT-1:0] ras_n_i,
    output logic [LINE_CNT-1:0] line_mask_o,
    output logic                ready_o
);
    for (genvar i = 0; i < LINE_CNT; i++) begin : g_mask
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        // Line selection for this index under the current mode.
        always_comb begin
            if (dual_i) begin
                line_mask_o[i] = (IDX[0] == bank_sel_i[0]);
            end else begin
                line_mask_o[i] = (IDX == bank_sel_i);
            end
        end
    end

    // Eligibility: all targeted lines free, plus the all-high gap if no overlap.
    always_comb begin
        ready_o = (&(idle_i | ~line_mask_o)) && (pipe_i || (&ras_n_i));
    end
endmodule

// File: rtl/bank_strobe_seq.sv
// Module: top of the interleaved bank strobe sequencer.
// Accepts a request when req_i and ready_o are high at a rising edge and
// starts the targeted line timers. Outputs come from registered timer state.
module bank_strobe_seq
    import ras_seq_pkg::*;
#(
    parameter int ACC_CYC = 5,
    parameter int RCD_CYC = 2,
    parameter int PRE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [SEL_W-1:0]    bank_sel_i,
    input  logic                dual_ras_i,
    input  logic                pipe_en_i,
    output logic                ready_o,
    output logic [LINE_CNT-1:0] ras_n_o,
    output logic [LINE_CNT-1:0] cas_n_o
);
    logic [LINE_CNT-1:0] line_mask;
    logic [LINE_CNT-1:0] line_idle;
    logic [LINE_CNT-1:0] line_start;
    logic                accept;

    ras_grant_logic u_grant (
        .bank_sel_i (bank_sel_i),
        .dual_i     (dual_ras_i),
        .pipe_i     (pipe_en_i),
        .idle_i     (line_idle),
        .ras_n_i    (ras_n_o),
        .line_mask_o(line_mask),
        .ready_o    (ready_o)
    );

    // Start pulses for the targeted lines on an accepted request.
    always_comb begin
        accept     = req_i && ready_o;
        line_start = line_mask & {LINE_CNT{accept}};
    end

    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
        ras_line_timer #(
            .ACC_CYC(ACC_CYC),
            .RCD_CYC(RCD_CYC),
            .PRE_CYC(PRE_CYC)
        ) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(line_start[i]),
            .idle_o (line_idle[i]),
            .ras_n_o(ras_n_o[i]),
            .cas_n_o(cas_n_o[i])
        );
    end

    logic                pipe_q;
    logic [LINE_CNT-1:0] ras_n_q;

    // Previous-cycle mode and strobes, kept for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q  <= 1'b0;
            ras_n_q <= '1;
        end else begin
            pipe_q  <= pipe_en_i;
            ras_n_q <= ras_n_o;
        end
    end

    // R6
    all_high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_q && (|(ras_n_q & ~ras_n_o))) |-> (&ras_n_q));

    // R8
    dual_pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dual_ras_i && !bank_sel_i[0]) |=> (!ras_n_o[0] && !ras_n_o[2]));

    // R8
    dual_pair_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dual_ras_i && bank_sel_i[0]) |=> (!ras_n_o[1] && !ras_n_o[3]));
endmodule

// File: tb/bank_strobe_seq_tb.sv
// Bench: directed corner cases plus seeded random traffic, every cycle checked
// against a clock-by-clock model of the strobe rules.
module bank_strobe_seq_tb_top;
    localparam int ACC = 5;
    localparam int RCD = 2;
    localparam int PRE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] bsel = 2'd0;
    logic       dual = 1'b0;
    logic       pipe = 1'b0;
    logic       ready;
    logic [3:0] ras_n;
    logic [3:0] cas_n;

    int n_total = 0;
    int n_fail  = 0;
    logic last_ready;

    int m_act [4];
    int m_age [4];
    int m_pre [4];

    always #10 clk = ~clk;

    bank_strobe_seq #(.ACC_CYC(ACC), .RCD_CYC(RCD), .PRE_CYC(PRE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .bank_sel_i(bsel),
        .dual_ras_i(dual), .pipe_en_i(pipe), .ready_o(ready),
        .ras_n_o(ras_n), .cas_n_o(cas_n)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] b, input logic d);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = d ? (i[0] == b[0]) : (i == int'(b));
        return m;
    endfunction

    function automatic logic exp_ready(input logic [1:0] b, input logic d, input logic p);
        logic [3:0] m;
        logic ok;
        m = exp_mask(b, d);
        ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (m[i] && (m_act[i] != 0 || m_pre[i] != 0)) ok = 1'b0;
            if (!p && m_act[i] != 0) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [3:0] exp_ras();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = (m_act[i] == 0);
        return r;
    endfunction

    function automatic logic [3:0] exp_cas();
        logic [3:0] c;
        for (int i = 0; i < 4; i++) c[i] = !(m_act[i] != 0 && m_age[i] >= RCD);
        return c;
    endfunction

    task automatic model_clock(input logic [3:0] st);
        for (int i = 0; i < 4; i++) begin
            if (m_act[i] != 0) begin
                if (m_age[i] == ACC - 1) begin
                    m_act[i] = 0;
                    m_pre[i] = PRE;
                end else begin
                    m_age[i]++;
                end
            end else if (m_pre[i] > 0) begin
                m_pre[i]--;
            end
            if (st[i]) begin
                m_act[i] = 1;
                m_age[i] = 0;
            end
        end
    endtask

    // One clock: drive at the falling edge, check ready, clock, check strobes.
    task automatic step(input logic rq, input logic [1:0] b, input logic d, input logic p);
        logic er;
        string rtag;
        req = rq; bsel = b; dual = d; pipe = p;
        #1;
        er = exp_ready(b, d, p);
        rtag = d ? "R8 ready" : (p ? "R5 ready" : "R6 ready");
        check(ready === er, rtag, int'(ready), int'(er));
        last_ready = ready;
        @(posedge clk);
        model_clock((rq && er) ? exp_mask(b, d) : 4'b0000);
        @(negedge clk);
        check(ras_n === exp_ras(), "R2 ras", int'(ras_n), int'(exp_ras()));
        check(cas_n === exp_cas(), "R3 cas", int'(cas_n), int'(exp_cas()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int phase;
        int hi;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) begin
            m_act[i] = 0; m_age[i] = 0; m_pre[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle strobes and ready for every select and mode
        check(ras_n === 4'hF, "R1 ras", int'(ras_n), 15);
        check(cas_n === 4'hF, "R1 cas", int'(cas_n), 15);
        for (int b = 0; b < 4; b++) begin
            bsel = 2'(b); dual = b[1]; pipe = b[0];
            #1;
            check(ready === 1'b1, "R1 ready", int'(ready), 1);
        end

        // R2: single access on line 2
        step(1'b1, 2'd2, 1'b0, 1'b0);
        check(ras_n === 4'b1011, "R2 line", int'(ras_n), 11);
        check(cas_n === 4'hF, "R3 early", int'(cas_n), 15);
        // R6 / R9: other bank blocked while a RAS is low, strobes untouched
        step(1'b1, 2'd1, 1'b0, 1'b0);
        check(last_ready === 1'b0, "R6 blocked", int'(last_ready), 0);
        check(ras_n[1] === 1'b1, "R9 no start", int'(ras_n[1]), 1);
        step(1'b0, 2'd0, 1'b0, 1'b0);
        check(cas_n[2] === 1'b0, "R3 delay", int'(cas_n[2]), 0);
        repeat (8) step(1'b1, 2'd1, 1'b0, 1'b0);
        repeat (12) step(1'b0, 2'd0, 1'b0, 1'b0);

        // R4: same-line repeat with overlap on, measure the high run
        phase = 0; hi = 0;
        for (int k = 0; k < 30; k++) begin
            step(1'b1, 2'd3, 1'b0, 1'b1);
            if (phase == 0 && !ras_n[3]) phase = 1;
            else if (phase == 1 && ras_n[3]) begin phase = 2; hi = 1; end
            else if (phase == 2 && ras_n[3]) hi++;
            else if (phase == 2 && !ras_n[3]) phase = 3;
        end
        check(hi == PRE + 1, "R4 high run", hi, PRE + 1);
        repeat (12) step(1'b0, 2'd0, 1'b0, 1'b1);

        // R7 / R5: overlapping strobes on lines 0 and 1
        step(1'b1, 2'd0, 1'b0, 1'b1);
        step(1'b1, 2'd1, 1'b0, 1'b1);
        check(ras_n[1:0] === 2'b00, "R7 overlap", int'(ras_n[1:0]), 0);
        repeat (12) step(1'b0, 2'd0, 1'b0, 1'b0);

        // R8: dual mode with select bit 1 set still picks lines 0 and 2
        step(1'b1, 2'b10, 1'b1, 1'b0);
        check(ras_n === 4'b1010, "R8 pair", int'(ras_n), 10);
        repeat (12) step(1'b0, 2'd0, 1'b0, 1'b0);

        // Seeded random traffic across all modes
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4),
                 ($urandom % 4) == 0, 1'($urandom % 2));
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule